// File: doc/BRIEF.md
# Power-Good and Reset Sequencer

This block turns raw "supply stable" and "clock stable" status bits into a clean power-good level and an active-low processor reset. Every status bit crosses into the reference clock through a two-flop synchronizer. The bits must then agree for a programmed number of consecutive cycles before the block treats them as stable. Power-good rises only after it has been low for a minimum time and the inputs have been stable for the debounce window. Reset is then held for a programmed number of reference-clock cycles, which must lie between 1 ms and 10 ms. On the cycle that reset releases, the block captures a configuration word and marks it with a one-cycle strobe.

If any status bit drops while the sequence is in progress or finished, power-good and reset are both pulled low on the same clock edge. The whole sequence then starts again from the low-time wait. Every time in the block is counted in cycles of the free-running reference clock. An asynchronous active-low input clears the sequencer at power-on.

Top module: `psu_reset_seq`

## Requirements
- R1: While `arst_n` is low, `pwr_good`, `cpu_rst_n` and `cfg_valid` are 0, and `cfg_word` is all zeros.
- R2: The inputs count as stable only after the AND of all synchronized status bits has been 1 for DEB_CYC consecutive cycles. A shorter high pulse leaves `pwr_good` at 0.
- R3: `pwr_good` rises once per power cycle and does not toggle while the inputs stay stable.
- R4: Before each rise, `pwr_good` has been low for at least LOW_MIN_CYC cycles. This holds after `arst_n` releases and after every drop.
- R5: After `pwr_good` rises, `cpu_rst_n` stays 0 for exactly HOLD_CYC cycles and then goes to 1.
- R6: On the clock edge where `cpu_rst_n` rises, `cfg_word` loads `cfg_in`. `cfg_valid` is 1 for that one cycle only.
- R7: A status bit that falls forces `pwr_good` and `cpu_rst_n` both to 0 on the fourth rising clock edge after the fall: two synchronizer stages, one filter stage and one state stage.
- R8: `cpu_rst_n` is never 1 while `pwr_good` is 0.
- R9: HOLD_CYC lies between CLK_HZ/1000 and CLK_HZ/100, which is 1 ms to 10 ms. Elaboration stops with an error if it does not.
- R10: `cfg_word` keeps its value in every cycle where `cfg_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| arst_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok_raw | input | N_SUP | Unsynchronized per-rail stable flags |
| clk_ok_raw | input | 1 | Unsynchronized clock-stable flag |
| cfg_in | input | CFG_W | Configuration word to capture at reset release |
| pwr_good | output | 1 | Clean power-good level |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cfg_word | output | CFG_W | Configuration captured at the last reset release |
| cfg_valid | output | 1 | One-cycle strobe marking a new `cfg_word` |

## Verification
Each result has a fixed delay from its cause. A status fall reaches both outputs on the fourth rising edge. Power-good rises one edge after the debounced stable flag is seen in the wait state. Reset releases HOLD_CYC edges after power-good rises, and the configuration is captured on that same edge. The bench's behavioural model steps once per rising edge and applies these delays. Outputs are compared at every falling edge, half a cycle after they settle. Directed checks count falling edges from a stimulus, so a delay that is off by one edge shows up as a miscompare.

// File: rtl/psu_reset_seq.sv
module psu_reset_seq #(
  parameter int N_SUP       = 2,
  parameter int CFG_W       = 8,
  parameter int CLK_HZ      = 25_000_000,
  parameter int DEB_CYC     = 16,
  parameter int LOW_MIN_CYC = 1000,
  parameter int HOLD_CYC    = 50_000
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [N_SUP-1:0] supply_ok_raw,
  input  logic             clk_ok_raw,
  input  logic [CFG_W-1:0] cfg_in,
  output logic             pwr_good,
  output logic             cpu_rst_n,
  output logic [CFG_W-1:0] cfg_word,
  output logic             cfg_valid
);
  localparam int MAXC = (HOLD_CYC > LOW_MIN_CYC) ? HOLD_CYC : LOW_MIN_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int DW   = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_MIN_CYC - 1);
  localparam logic [DW-1:0] DEB_LAST  = DW'(DEB_CYC - 1);

  // R9: reset hold must land inside the 1 ms .. 10 ms window
  if (HOLD_CYC < CLK_HZ / 1000 || HOLD_CYC > CLK_HZ / 100) begin : g_bad_hold
    $error("HOLD_CYC outside 1..10 ms at CLK_HZ");
  end
  if (DEB_CYC < 1 || LOW_MIN_CYC < 1) begin : g_bad_cnt
    $error("DEB_CYC and LOW_MIN_CYC must be at least 1");
  end

  typedef enum logic [1:0] {S_OFF, S_WAIT, S_HOLD, S_RUN} state_t;

  logic [N_SUP:0] sync1, sync2;
  logic           all_ok, stable;
  logic [DW-1:0]  deb_cnt;
  logic [CW-1:0]  cnt;
  state_t         state;

  assign all_ok = &sync2;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {clk_ok_raw, supply_ok_raw};
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      deb_cnt <= '0;
      stable  <= 1'b0;
    end else if (!all_ok) begin
      deb_cnt <= '0;
      stable  <= 1'b0;
    end else if (deb_cnt == DEB_LAST) begin
      stable  <= 1'b1;
    end else begin
      deb_cnt <= deb_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state     <= S_OFF;
      cnt       <= '0;
      pwr_good  <= 1'b0;
      cpu_rst_n <= 1'b0;
      cfg_word  <= '0;
      cfg_valid <= 1'b0;
    end else begin
      cfg_valid <= 1'b0;
      unique case (state)
        S_OFF: begin
          pwr_good  <= 1'b0;
          cpu_rst_n <= 1'b0;
          if (cnt == LOW_LAST) begin
            state <= S_WAIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (stable) begin
            state    <= S_HOLD;
            pwr_good <= 1'b1;
            cnt      <= '0;
          end
        end
        S_HOLD: begin
          if (!stable) begin
            state    <= S_OFF;
            pwr_good <= 1'b0;
            cnt      <= '0;
          end else if (cnt == HOLD_LAST) begin
            state     <= S_RUN;
            cpu_rst_n <= 1'b1;
            cfg_word  <= cfg_in;
            cfg_valid <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RUN: begin
          if (!stable) begin
            state     <= S_OFF;
            pwr_good  <= 1'b0;
            cpu_rst_n <= 1'b0;
            cnt       <= '0;
          end
        end
        default: state <= S_OFF;
      endcase
    end
  end
endmodule

// File: rtl/psu_reset_seq_chk.sv
module psu_reset_seq_chk #(
  parameter int CFG_W       = 8,
  parameter int LOW_MIN_CYC = 1000,
  parameter int HOLD_CYC    = 50_000
) (
  input logic             clk,
  input logic             arst_n,
  input logic             pwr_good,
  input logic             cpu_rst_n,
  input logic [CFG_W-1:0] cfg_word,
  input logic             cfg_valid
);
  int unsigned hold_n, low_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_n <= 0;
      low_n  <= 0;
    end else begin
      hold_n <= (pwr_good && !cpu_rst_n) ? hold_n + 1 : 0;
      if (pwr_good) low_n <= 0;
      else if (low_n < LOW_MIN_CYC) low_n <= low_n + 1;
    end
  end

  AST_RST_NEEDS_PG: assert property (@(posedge clk) disable iff (!arst_n)
    cpu_rst_n |-> pwr_good); // R8
  AST_HOLD_EXACT: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(cpu_rst_n) |-> hold_n == HOLD_CYC); // R5
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    (pwr_good && !cpu_rst_n) |-> hold_n < HOLD_CYC); // R5
  AST_PG_LOW_MIN: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(pwr_good) |-> low_n >= LOW_MIN_CYC); // R4
  AST_VALID_ON_RELEASE: assert property (@(posedge clk) disable iff (!arst_n)
    cfg_valid |-> $rose(cpu_rst_n)); // R6
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!arst_n)
    cfg_valid |=> !cfg_valid); // R6
  AST_CFG_STEADY: assert property (@(posedge clk) disable iff (!arst_n)
    !cfg_valid |-> $stable(cfg_word)); // R10
endmodule

bind psu_reset_seq psu_reset_seq_chk #(
  .CFG_W(CFG_W), .LOW_MIN_CYC(LOW_MIN_CYC), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk(clk), .arst_n(arst_n), .pwr_good(pwr_good), .cpu_rst_n(cpu_rst_n),
  .cfg_word(cfg_word), .cfg_valid(cfg_valid)
);

// File: tb/psu_reset_seq_bench.sv
`timescale 1ns/1ps
module psu_reset_seq_bench;
  localparam int NS = 3, CW = 8, HZ = 10_000, DEB = 3, LOW = 6, HOLD = 25;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic [NS-1:0] sup = '0;
  logic clk_ok = 1'b0;
  logic [CW-1:0] cfg_in = '0;
  logic pg, rstn, valid;
  logic [CW-1:0] cfg_word;

  always #2 clk = ~clk;

  psu_reset_seq #(.N_SUP(NS), .CFG_W(CW), .CLK_HZ(HZ), .DEB_CYC(DEB),
    .LOW_MIN_CYC(LOW), .HOLD_CYC(HOLD)) u_psu_reset_seq (
    .clk(clk), .arst_n(arst_n), .supply_ok_raw(sup), .clk_ok_raw(clk_ok),
    .cfg_in(cfg_in), .pwr_good(pg), .cpu_rst_n(rstn), .cfg_word(cfg_word),
    .cfg_valid(valid));

  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, one step per rising edge
  int p1, p2, run, st, ph, cnt, old_ok, old_st;
  logic e_pg, e_rstn, e_valid;
  logic [CW-1:0] e_cfg;
  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      p1 = 0; p2 = 0; run = 0; st = 0; ph = 0; cnt = 0;
      e_pg = 0; e_rstn = 0; e_valid = 0; e_cfg = '0;
    end else begin
      old_ok = p2; old_st = st; p2 = p1;
      p1 = ((&sup) && clk_ok) ? 1 : 0;
      if (old_ok == 0) begin run = 0; st = 0; end
      else if (run == DEB - 1) st = 1;
      else run++;
      e_valid = 0;
      if (ph == 0) begin
        e_pg = 0; e_rstn = 0;
        if (cnt == LOW - 1) begin ph = 1; cnt = 0; end else cnt++;
      end else if (ph == 1) begin
        if (old_st != 0) begin ph = 2; e_pg = 1; cnt = 0; end
      end else if (ph == 2) begin
        if (old_st == 0) begin ph = 0; e_pg = 0; cnt = 0; end
        else if (cnt == HOLD - 1) begin ph = 3; e_rstn = 1; e_cfg = cfg_in; e_valid = 1; end
        else cnt++;
      end else begin
        if (old_st == 0) begin ph = 0; e_pg = 0; e_rstn = 0; cnt = 0; end
      end
    end
  end

  int hold_seen = 0, low_seen = 0;
  logic prev_pg = 0, prev_rstn = 0;
  always @(negedge clk) begin
    if (arst_n) begin
      chk(pg === e_pg, "R3 pwr_good", pg, e_pg);
      chk(rstn === e_rstn, "R5 cpu_rst_n", rstn, e_rstn);
      chk(valid === e_valid, "R6 cfg_valid", valid, e_valid);
      chk(cfg_word === e_cfg, "R10 cfg_word", cfg_word, e_cfg);
      chk(!(rstn && !pg), "R8 reset without power-good", rstn, 0);
      if (rstn && !prev_rstn) begin
        chk(hold_seen == HOLD, "R5 reset width", hold_seen, HOLD);
        chk(hold_seen >= HZ / 1000 && hold_seen <= HZ / 100, "R9 width in 1..10 ms", hold_seen, HOLD);
      end
      if (pg && !prev_pg)
        chk(low_seen >= LOW, "R4 low time before rise", low_seen, LOW);
      hold_seen = (pg && !rstn) ? hold_seen + 1 : 0;
      low_seen  = pg ? 0 : low_seen + 1;
      prev_pg = pg; prev_rstn = rstn;
    end else begin
      hold_seen = 0; low_seen = 0; prev_pg = 0; prev_rstn = 0;
    end
  end

  always @(negedge clk) cfg_in <= cfg_in + 8'd37;

  task automatic wait_rstn();
    for (int i = 0; i < 400 && !rstn; i++) @(negedge clk);
  endtask

  task automatic drop_check(bit use_clk, string tag);
    int n = 0;
    if (use_clk) clk_ok = 0; else sup[1] = 0;
    while (pg && n < 20) begin @(negedge clk); n++; end
    chk(n == 4, tag, n, 4);
    chk(rstn == 0, "R7 reset drops with power-good", rstn, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pg == 0 && rstn == 0 && valid == 0, "R1 reset outputs", {pg, rstn, valid}, 0);
    chk(cfg_word == 0, "R1 cfg_word cleared", cfg_word, 0);
    arst_n = 1;
    repeat (2) @(negedge clk);
    sup = '1; clk_ok = 1;
    wait_rstn();
    chk(rstn == 1, "R5 first release reached", rstn, 1);
    repeat (5) @(negedge clk);
    drop_check(0, "R7 supply drop delay");
    repeat (12) @(negedge clk);
    sup = '1;
    repeat (2) @(negedge clk);
    sup[0] = 0;
    repeat (20) @(negedge clk);
    chk(pg == 0, "R2 short pulse filtered", pg, 0);
    sup = '1;
    for (int i = 0; i < 100 && !pg; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    clk_ok = 0;
    repeat (6) @(negedge clk);
    chk(pg == 0 && rstn == 0, "R7 drop during hold", pg, 0);
    clk_ok = 1;
    wait_rstn();
    chk(rstn == 1, "R3 second release reached", rstn, 1);
    repeat (8) @(negedge clk);
    drop_check(1, "R7 clock-ok drop delay");
    clk_ok = 1;
    wait_rstn();
    repeat (3) @(negedge clk);
    arst_n = 0;
    @(negedge clk);
    chk(pg == 0 && rstn == 0 && cfg_word == 0, "R1 mid-run clear", {pg, rstn}, 0);
    arst_n = 1;
    wait_rstn();
    chk(rstn == 1, "R5 release after clear", rstn, 1);
    repeat (10) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule